// File: doc/BRIEF.md
# RC4 Boot Image Decryptor

This block turns an encrypted boot image into plaintext with the RC4 stream cipher and then decides whether the result is usable. Software or a boot sequencer first loads a 16-byte key into the block one byte at a time, then pulses `start`. The block builds its 256-entry permutation table in a private single-port RAM, mixes the key into that table, and then generates one keystream byte per image byte. It fetches each ciphertext byte from a source memory port and writes the XOR result to a destination memory port. The image is a fixed 24 KiB by default.

While the plaintext is written out, the block collects the four bytes at a fixed check offset as a little-endian word. At the end it compares that word against a magic constant. A match raises `pass` and presents the start of the decrypted image as the entry address. A mismatch presents a fixed fallback address. The block does not jump anywhere itself.

The controller is one state machine. `ST_IDLE` waits for a start. `ST_FILL` writes the identity permutation. `ST_KS_RDI`, `ST_KS_RDJ`, `ST_KS_WRI` and `ST_KS_WRJ` carry out one key-schedule swap in four cycles. `ST_X_RDI`, `ST_X_RDJ`, `ST_X_WRI`, `ST_X_WRJ`, `ST_X_RDK` and `ST_X_OUT` produce one plaintext byte in six cycles. `ST_CHECK` compares the signature and returns to `ST_IDLE`.

The transitions are:
- `ST_IDLE` to `ST_FILL` on start.
- `ST_FILL` to `ST_KS_RDI` after entry 255.
- `ST_KS_WRJ` back to `ST_KS_RDI`, or to `ST_X_RDI` after index 255.
- `ST_X_OUT` back to `ST_X_RDI`, or to `ST_CHECK` after the last byte.
- `ST_CHECK` to `ST_IDLE`.

Top module: `rc4_image_unlock`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `pass`, `src_req` and `dst_we` are all 0.
- R2: `start` seen while `busy` is 0 makes `busy` 1 on the next cycle. `start` seen while `busy` is 1 is ignored: the run in progress neither restarts nor changes its output.
- R3: When `busy` is 0, `key_we` stores `key_byte` as key byte number `key_idx`. When `busy` is 1, key writes are ignored and the run in progress keeps using the key it started with.
- R4: The permutation table starts as S[n] = n. Then, for i from 0 to 255 with j starting at 0, the block sets j = j + S[i] + key[i mod 16] (mod 256) and swaps S[i] with S[j].
- R5: Keystream generation starts with i = j = 0. For each byte, i is incremented, then j = j + S[i], then S[i] and S[j] are swapped. The keystream byte is S[(S[i]+S[j]) mod 256]. Plaintext byte k equals source byte k XOR keystream byte k.
- R6: Source byte k is requested once, at `SRC_BASE + k`, in increasing k. Its data is taken from `src_rdata` one cycle after `src_req`. Plaintext byte k is written once, at `DST_BASE + k`, in increasing k. There are exactly `IMG_LEN` writes.
- R7: Plaintext bytes at offsets `CHK_OFF` to `CHK_OFF+3` form a little-endian word, with the byte at `CHK_OFF` in bits 7:0. If that word equals `MAGIC`, `pass` is 1 and `entry_addr` is `GOOD_ENTRY` (0x00090000). Otherwise `pass` is 0 and `entry_addr` is `BAD_ENTRY` (0xFFFFFF94).
- R8: At the end of a run, `done` rises with `busy` 0. `done` holds until the next accepted start and is 0 on the cycle after that start.
- R9: `src_req` and `dst_we` are never 1 in the same cycle, and neither is 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a decryption run |
| key_we | input | 1 | Key byte write strobe |
| key_idx | input | 4 | Key byte index |
| key_byte | input | 8 | Key byte value |
| src_req | output | 1 | Ciphertext read request |
| src_addr | output | 32 | Ciphertext byte address |
| src_rdata | input | 8 | Ciphertext byte, one cycle after request |
| dst_we | output | 1 | Plaintext write strobe |
| dst_addr | output | 32 | Plaintext byte address |
| dst_wdata | output | 8 | Plaintext byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Signature matched |
| entry_addr | output | 32 | Selected entry address |

## Verification
Any fault in the permutation table or in the i/j indices corrupts the keystream. Such a fault therefore shows up at `dst_wdata` on the very next plaintext write, and from then on nearly every later byte is wrong. Byte-by-byte comparison against a model of the cipher catches a bad swap within about six cycles of the write. A miscounted length or a wrong address step shows up on `dst_addr` or as a wrong write count. A wrong assembly of the check word shows up only at the end, as `pass` and `entry_addr` disagreeing with the plaintext. For that reason one vector differs from the magic word in its top byte alone.

// File: rtl/rc4_unlock_pkg.sv
package rc4_unlock_pkg;
    localparam int BYTE_W  = 8;
    localparam int SBOX_AW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_KS_RDI,
        ST_KS_RDJ,
        ST_KS_WRI,
        ST_KS_WRJ,
        ST_X_RDI,
        ST_X_RDJ,
        ST_X_WRI,
        ST_X_WRJ,
        ST_X_RDK,
        ST_X_OUT,
        ST_CHECK
    } phase_e;
endpackage

// File: rtl/rc4_sbox_ram.sv
module rc4_sbox_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // single port, synchronous read (old data on a write cycle)
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/rc4_key_bank.sv
module rc4_key_bank #(
    parameter int NBYTES = 16,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(NBYTES)-1:0] widx,
    input  logic [DW-1:0]             wdata,
    input  logic [$clog2(NBYTES)-1:0] ridx,
    output logic [DW-1:0]             rdata
);
    logic [DW-1:0] kb [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          kb[g] <= '0;
            else if (we && widx == g[$clog2(NBYTES)-1:0]) kb[g] <= wdata;
        end
    end

    assign rdata = kb[ridx];
endmodule

// File: rtl/rc4_image_unlock.sv
module rc4_image_unlock
    import rc4_unlock_pkg::*;
#(
    parameter int                IMG_LEN    = 24576,
    parameter int                KEY_BYTES  = 16,
    parameter int                CHK_OFF    = 24548,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] SRC_BASE   = 32'hFFFF_9E00,
    parameter logic [ADDR_W-1:0] DST_BASE   = 32'h0009_0000,
    parameter logic [ADDR_W-1:0] GOOD_ENTRY = 32'h0009_0000,
    parameter logic [ADDR_W-1:0] BAD_ENTRY  = 32'hFFFF_FF94,
    parameter logic [31:0]       MAGIC      = 32'h7A5C_E11D
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         key_we,
    input  logic [$clog2(KEY_BYTES)-1:0] key_idx,
    input  logic [7:0]                   key_byte,
    output logic                         src_req,
    output logic [ADDR_W-1:0]            src_addr,
    input  logic [7:0]                   src_rdata,
    output logic                         dst_we,
    output logic [ADDR_W-1:0]            dst_addr,
    output logic [7:0]                   dst_wdata,
    output logic                         busy,
    output logic                         done,
    output logic                         pass,
    output logic [ADDR_W-1:0]            entry_addr
);
    localparam int                KEY_IW = $clog2(KEY_BYTES);
    localparam int                CNT_W  = $clog2(IMG_LEN + 1);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(IMG_LEN - 1);
    localparam logic [CNT_W-1:0]  CHK_LO = CNT_W'(CHK_OFF);
    localparam logic [SBOX_AW-1:0] TOP   = '1;

    phase_e state, state_nx;

    logic [SBOX_AW-1:0] i_q, j_q;
    logic [BYTE_W-1:0]  si_q, sj_q, cbyte_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [31:0]        chk_q;
    logic               done_q, pass_q;
    logic [ADDR_W-1:0]  entry_q;

    logic               ram_we;
    logic [SBOX_AW-1:0] ram_addr;
    logic [BYTE_W-1:0]  ram_wdata, ram_rdata;
    logic [BYTE_W-1:0]  key_rd;
    logic [SBOX_AW-1:0] j_ks;
    logic [CNT_W-1:0]   chk_rel;
    logic               in_win;

    rc4_sbox_ram #(.AW(SBOX_AW), .DW(BYTE_W)) sbox_i (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    rc4_key_bank #(.NBYTES(KEY_BYTES), .DW(BYTE_W)) keys_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (key_we && state == ST_IDLE),
        .widx  (key_idx),
        .wdata (key_byte),
        .ridx  (i_q[KEY_IW-1:0]),
        .rdata (key_rd)
    );

    assign j_ks    = j_q + ram_rdata + key_rd;
    assign chk_rel = cnt_q - CHK_LO;
    assign in_win  = (cnt_q >= CHK_LO) && (chk_rel < CNT_W'(4));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_FILL;
            ST_FILL:   if (i_q == TOP) state_nx = ST_KS_RDI;
            ST_KS_RDI: state_nx = ST_KS_RDJ;
            ST_KS_RDJ: state_nx = ST_KS_WRI;
            ST_KS_WRI: state_nx = ST_KS_WRJ;
            ST_KS_WRJ: state_nx = (i_q == TOP) ? ST_X_RDI : ST_KS_RDI;
            ST_X_RDI:  state_nx = ST_X_RDJ;
            ST_X_RDJ:  state_nx = ST_X_WRI;
            ST_X_WRI:  state_nx = ST_X_WRJ;
            ST_X_WRJ:  state_nx = ST_X_RDK;
            ST_X_RDK:  state_nx = ST_X_OUT;
            ST_X_OUT:  state_nx = (cnt_q == LAST) ? ST_CHECK : ST_X_RDI;
            ST_CHECK:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and table port
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = i_q;
        ram_wdata = ram_rdata;
        src_req   = 1'b0;
        dst_we    = 1'b0;
        unique case (state)
            ST_FILL:   begin ram_we = 1'b1; ram_wdata = i_q; end
            ST_KS_RDJ: ram_addr = j_ks;
            ST_KS_WRI: ram_we = 1'b1;
            ST_KS_WRJ: begin ram_we = 1'b1; ram_addr = j_q; ram_wdata = si_q; end
            ST_X_RDI:  begin ram_addr = i_q + 8'd1; src_req = 1'b1; end
            ST_X_RDJ:  ram_addr = j_q + ram_rdata;
            ST_X_WRI:  ram_we = 1'b1;
            ST_X_WRJ:  begin ram_we = 1'b1; ram_addr = j_q; ram_wdata = si_q; end
            ST_X_RDK:  ram_addr = si_q + sj_q;
            ST_X_OUT:  dst_we = 1'b1;
            default:   ;
        endcase
    end

    assign src_addr   = SRC_BASE + ADDR_W'(cnt_q);
    assign dst_addr   = DST_BASE + ADDR_W'(cnt_q);
    assign dst_wdata  = cbyte_q ^ ram_rdata;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign pass       = pass_q;
    assign entry_addr = entry_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0; j_q <= '0; si_q <= '0; sj_q <= '0; cbyte_q <= '0;
            cnt_q <= '0; chk_q <= '0; done_q <= 1'b0; pass_q <= 1'b0;
            entry_q <= BAD_ENTRY;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    i_q <= '0; j_q <= '0; cnt_q <= '0; chk_q <= '0;
                    done_q <= 1'b0; pass_q <= 1'b0;
                end
                ST_FILL:   i_q <= i_q + 8'd1;
                ST_KS_RDJ: begin si_q <= ram_rdata; j_q <= j_ks; end
                ST_KS_WRJ: begin
                    i_q <= i_q + 8'd1;
                    if (i_q == TOP) j_q <= '0;
                end
                ST_X_RDI:  i_q <= i_q + 8'd1;
                ST_X_RDJ:  begin
                    si_q    <= ram_rdata;
                    j_q     <= j_q + ram_rdata;
                    cbyte_q <= src_rdata;
                end
                ST_X_WRI:  sj_q <= ram_rdata;
                ST_X_OUT:  begin
                    if (in_win) begin
                        case (chk_rel[1:0])
                            2'd0: chk_q[7:0]   <= dst_wdata;
                            2'd1: chk_q[15:8]  <= dst_wdata;
                            2'd2: chk_q[23:16] <= dst_wdata;
                            default: chk_q[31:24] <= dst_wdata;
                        endcase
                    end
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_CHECK:  begin
                    pass_q  <= (chk_q == MAGIC);
                    entry_q <= (chk_q == MAGIC) ? GOOD_ENTRY : BAD_ENTRY;
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rc4_unlock_chk.sv
module rc4_unlock_chk #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] DST_BASE   = '0,
    parameter logic [ADDR_W-1:0] GOOD_ENTRY = '0,
    parameter logic [ADDR_W-1:0] BAD_ENTRY  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              src_req,
    input logic              dst_we,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [ADDR_W-1:0] entry_addr
);
    logic [ADDR_W-1:0] wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               wr_seen <= '0;
        else if (start && !busy)  wr_seen <= '0;
        else if (dst_we)          wr_seen <= wr_seen + 1'b1;
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_req && !dst_we));

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_req && dst_we));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !done);

    // R7
    entry_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (entry_addr == (pass ? GOOD_ENTRY : BAD_ENTRY)));

    // R6
    dst_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dst_addr == DST_BASE + wr_seen));
endmodule

bind rc4_image_unlock rc4_unlock_chk #(
    .ADDR_W     (ADDR_W),
    .DST_BASE   (DST_BASE),
    .GOOD_ENTRY (GOOD_ENTRY),
    .BAD_ENTRY  (BAD_ENTRY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .src_req    (src_req),
    .dst_we     (dst_we),
    .dst_addr   (dst_addr),
    .entry_addr (entry_addr)
);

// File: tb/rc4_image_unlock_tb_top.sv
`timescale 1ns/1ps
module rc4_image_unlock_tb_top;
    localparam int          T_LEN   = 64;
    localparam int          T_CHK   = 56;
    localparam int          TIW     = $clog2(T_LEN);
    localparam logic [31:0] T_MAGIC = 32'hB007_5EA1;
    localparam logic [31:0] SBASE   = 32'hFFFF_9E00;
    localparam logic [31:0] DBASE   = 32'h0009_0000;
    localparam logic [31:0] GOOD    = 32'h0009_0000;
    localparam logic [31:0] BAD     = 32'hFFFF_FF94;

    // {key seed, plaintext seed, mode}: mode 1 plants magic, 2 plants magic with top byte flipped, 0 none
    localparam logic [23:0] VECS [4] = '{24'h5A_10_01, 24'hC3_77_02, 24'h00_00_01, 24'hFF_E1_00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        key_we = 1'b0;
    logic [3:0]  key_idx = '0;
    logic [7:0]  key_byte = '0;
    logic        src_req, dst_we, busy, done, pass;
    logic [31:0] src_addr, dst_addr, entry_addr;
    logic [7:0]  src_rdata, dst_wdata;

    int n_chk = 0, n_err = 0;

    logic [7:0] key_v [16];
    logic [7:0] ks_v  [T_LEN];
    logic [7:0] pt_v  [T_LEN];
    logic [7:0] src_mem [T_LEN];
    logic [7:0] dst_mem [T_LEN];
    int wr_count, rd_count, bad_addr, idle_act;
    logic clr_cnt = 1'b0;

    always #2 clk = ~clk;

    rc4_image_unlock #(
        .IMG_LEN(T_LEN), .CHK_OFF(T_CHK), .MAGIC(T_MAGIC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key_we(key_we),
        .key_idx(key_idx), .key_byte(key_byte), .src_req(src_req),
        .src_addr(src_addr), .src_rdata(src_rdata), .dst_we(dst_we),
        .dst_addr(dst_addr), .dst_wdata(dst_wdata), .busy(busy),
        .done(done), .pass(pass), .entry_addr(entry_addr)
    );

    // memory models and activity counters
    always @(posedge clk) begin
        logic [31:0] sidx, didx;
        sidx = src_addr - SBASE;
        didx = dst_addr - DBASE;
        if (clr_cnt) begin
            wr_count = 0; rd_count = 0; bad_addr = 0; idle_act = 0;
        end else begin
            if (!busy && (src_req || dst_we)) idle_act++;
            if (src_req) begin
                rd_count++;
                if (sidx < T_LEN) src_rdata <= src_mem[sidx[TIW-1:0]];
                else bad_addr++;
            end
            if (dst_we) begin
                wr_count++;
                if (didx < T_LEN) dst_mem[didx[TIW-1:0]] = dst_wdata;
                else bad_addr++;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // cipher model written from R4 and R5
    task automatic make_ks();
        logic [7:0] s [256];
        logic [7:0] j, t, ii;
        for (int n = 0; n < 256; n++) s[n] = 8'(n);
        j = 0;
        for (int n = 0; n < 256; n++) begin
            j = j + s[n] + key_v[n % 16];
            t = s[n]; s[n] = s[j]; s[j] = t;
        end
        ii = 0; j = 0;
        for (int k = 0; k < T_LEN; k++) begin
            ii = ii + 8'd1;
            j  = j + s[ii];
            t = s[ii]; s[ii] = s[j]; s[j] = t;
            t = s[ii] + s[j];
            ks_v[k] = s[t];
        end
    endtask

    task automatic load_key();
        for (int b = 0; b < 16; b++) begin
            key_we = 1'b1; key_idx = 4'(b); key_byte = key_v[b];
            tick();
        end
        key_we = 1'b0;
    endtask

    task automatic run_vec(input int vi, input bit disturb);
        logic [7:0]  kseed, pseed, mode;
        logic [31:0] word;
        bit          exp_pass, data_ok;
        int          first_bad;
        kseed = VECS[vi][23:16]; pseed = VECS[vi][15:8]; mode = VECS[vi][7:0];
        for (int b = 0; b < 16; b++) key_v[b] = kseed ^ 8'(b * 29);
        make_ks();
        for (int k = 0; k < T_LEN; k++) pt_v[k] = pseed + 8'(k * 7);
        word = (mode == 2) ? (T_MAGIC ^ 32'h8000_0000) : T_MAGIC;
        if (mode != 0) for (int b = 0; b < 4; b++) pt_v[T_CHK + b] = word[8*b +: 8];
        exp_pass = (mode == 1);
        for (int k = 0; k < T_LEN; k++) begin
            src_mem[k] = pt_v[k] ^ ks_v[k];
            dst_mem[k] = 8'h00;
        end
        load_key();
        clr_cnt = 1'b1; tick(); clr_cnt = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        check("R2", "busy after start", {31'b0, busy}, 32'd1);
        check("R8", "done cleared after start", {31'b0, done}, 32'd0);
        if (disturb) begin
            repeat (600) tick();
            // R3: key write during run must be ignored; R2: start during run ignored
            key_we = 1'b1; key_idx = 4'd0; key_byte = ~key_v[0]; tick(); key_we = 1'b0;
            repeat (300) tick();
            start = 1'b1; tick(); start = 1'b0;
        end
        for (int c = 0; c < 6000 && !done; c++) tick();
        data_ok = 1'b1; first_bad = 0;
        for (int k = T_LEN - 1; k >= 0; k--)
            if (dst_mem[k] !== pt_v[k]) begin data_ok = 1'b0; first_bad = k; end
        check(disturb ? "R3" : "R5", "plaintext matches model",
              {24'b0, dst_mem[first_bad]}, {24'b0, pt_v[first_bad]});
        check("R4", "all bytes decrypted", {31'b0, data_ok}, 32'd1);
        check("R6", "write count", wr_count, T_LEN);
        check(disturb ? "R2" : "R6", "read count", rd_count, T_LEN);
        check("R6", "out of range accesses", bad_addr, 0);
        check("R7", "pass flag", {31'b0, pass}, {31'b0, exp_pass});
        check("R7", "entry address", entry_addr, exp_pass ? GOOD : BAD);
        check("R8", "done with busy low", {30'b0, done, busy}, 32'd2);
        repeat (10) tick();
        check("R8", "done held", {31'b0, done}, 32'd1);
        check("R9", "no idle port activity", idle_act, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        clr_cnt = 1'b1;
        repeat (3) tick();
        // R1: values during reset
        check("R1", "busy/done/pass in reset", {29'b0, busy, done, pass}, 32'd0);
        check("R1", "ports quiet in reset", {30'b0, src_req, dst_we}, 32'd0);
        rst_n = 1'b1;
        tick();
        clr_cnt = 1'b0;
        check("R1", "idle after reset", {29'b0, busy, done, pass}, 32'd0);

        for (int v = 0; v < 4; v++) run_vec(v, v == 1);

        // R8: a fresh start clears done; the run then completes again
        run_vec(0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule